// File: doc/BRIEF.md
# Three-phase gate drive control logic

This block is the digital core that sits between a motor or inverter controller and six gate drivers of a three-phase bridge. For each phase it takes an active-low high-side command and an active-low low-side command and produces two active-high gate enables. Every command is debounced by a level filter, and the two enables of a phase are kept apart by a programmable dead time.

All six enables are forced off by three conditions. An over-current flag forces them off, but only once a blanking window that follows each turn-on has ended. An external shutdown input forces them off. A logic-supply undervoltage flag forces them off. Over-current and logic-supply undervoltage set an active-low fault flag. That flag holds until a clear pulse arrives while neither condition is present. A per-phase high-side supply flag disables only that phase's high enable. Comparator outputs arrive already digitised. All timing is counted in clock cycles set by parameters.

Top module: `gdrv_bridge_ctrl`

## Requirements
- R1: A command input that is low turns its gate enable on (1) and a high command turns it off. An idle bridge (all commands high) has all enables at 0.
- R2: A command change takes effect only after the new level has been sampled on FILT_CYC consecutive clock edges, so a shorter pulse never reaches the outputs. With the dead-time counter settled, a high-side enable rises FILT_CYC+1 clock edges after its command falls.
- R3: The high and low enables of one phase are never 1 together. When both commands of a phase are low, both enables of that phase are 0.
- R4: An enable turns on only after both enables of its phase have been 0 for DEAD_CYC cycles. When the commands of a phase swap at once, both enables stay off for exactly DEAD_CYC+1 cycles between the fall of one and the rise of the other.
- R5: When the over-current flag is 1 outside the blanking window, all six enables go to 0 at the next clock edge and fault_n_o goes to 0 at that same edge.
- R6: For BLANK_CYC cycles after any enable turns on, the over-current flag is ignored: outputs and fault_n_o do not change.
- R7: When the logic-supply undervoltage flag is 1, all six enables go to 0 at the next edge and fault_n_o is latched at 0.
- R8: fault_n_o stays 0 until fclr_i is 1 on an edge where both the over-current and logic-supply undervoltage flags are 0. A clear while either flag is 1 has no effect.
- R9: When sd_i is 1, all six enables are 0 from the next edge on. sd_i never drives fault_n_o low.
- R10: uv_hs_i bit p set to 1 turns off only the phase p high enable, from the next edge on. It leaves the other enables and fault_n_o unchanged.
- R11: After a forced shutdown ends, the filters restart from off. An enable whose command stayed low through the shutdown returns FILT_CYC+1 edges after the release edge, and not before.
- R12: During reset all enables are 0 and fault_n_o is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hin_ni | input | N_PH | High-side commands, active low, bit p = phase p |
| lin_ni | input | N_PH | Low-side commands, active low, bit p = phase p |
| itrip_i | input | 1 | Over-current flag, 1 = over-current |
| sd_i | input | 1 | External shutdown, 1 = force off |
| uv_vcc_i | input | 1 | Logic and low-side supply undervoltage, 1 = low |
| uv_hs_i | input | N_PH | Per-phase high-side supply undervoltage, 1 = low |
| fclr_i | input | 1 | Fault clear, 1 = clear request |
| ho_o | output | N_PH | High-side gate enables, 1 = on |
| lo_o | output | N_PH | Low-side gate enables, 1 = on |
| fault_n_o | output | 1 | Latched fault flag, 0 = fault |

## Verification
The bench builds the block with N_PH=3, FILT_CYC=4, DEAD_CYC=6 and BLANK_CYC=5. These short windows keep every timing rule within a few dozen cycles. The bench can therefore count edges exactly: the filter latency, the dead-time gap on a command swap, the end of blanking and the restart after a fault clear. It can also land a trip pulse wholly inside the blanking window and then one just after it.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;
endpackage

// File: rtl/gdrv_deglitch.sv
module gdrv_deglitch #(
  parameter int unsigned FILT_CYC = 31
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic raw_i,
  output logic q_o
);
  localparam int unsigned CW = $clog2(FILT_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      q_q   <= 1'b0;
    end else if (raw_i == q_q) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(FILT_CYC - 1)) begin
      cnt_q <= '0;
      q_q   <= raw_i;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/gdrv_phase_dt.sv
module gdrv_phase_dt
  import gdrv_pkg::*;
#(
  parameter int unsigned DEAD_CYC = 70
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_hi_i,
  input  logic       req_lo_i,
  input  logic       en_hi_i,
  input  logic       en_lo_i,
  output gate_pair_t gate_o,
  output logic       turn_on_o
);
  localparam int unsigned CW = $clog2(DEAD_CYC + 1);

  gate_pair_t    gate_q, gate_d;
  logic [CW-1:0] off_cnt_q;
  logic          both_off, dead_done;

  assign both_off  = !gate_q.hi && !gate_q.lo;
  assign dead_done = both_off && (off_cnt_q == CW'(DEAD_CYC));

  // both requested -> neither side driven
  always_comb begin
    gate_d.hi = en_hi_i && req_hi_i && !req_lo_i && (gate_q.hi || dead_done);
    gate_d.lo = en_lo_i && req_lo_i && !req_hi_i && (gate_q.lo || dead_done);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q    <= '0;
      off_cnt_q <= '0;
    end else begin
      gate_q <= gate_d;
      if (!both_off)                          off_cnt_q <= '0;
      else if (off_cnt_q != CW'(DEAD_CYC))    off_cnt_q <= off_cnt_q + CW'(1);
    end
  end

  assign gate_o    = gate_q;
  assign turn_on_o = (gate_d.hi && !gate_q.hi) || (gate_d.lo && !gate_q.lo);
endmodule

// File: rtl/gdrv_trip_guard.sv
module gdrv_trip_guard #(
  parameter int unsigned BLANK_CYC = 40
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic turn_on_i,
  input  logic itrip_i,
  input  logic uv_i,
  input  logic clr_i,
  output logic hazard_o,
  output logic fault_o
);
  localparam int unsigned CW = $clog2(BLANK_CYC + 1);

  logic [CW-1:0] blank_q;
  logic          fault_q, trip_hit, set_fault;

  assign trip_hit  = itrip_i && (blank_q == '0);
  assign set_fault = trip_hit || uv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blank_q <= '0;
    end else if (turn_on_i) begin
      blank_q <= CW'(BLANK_CYC);
    end else if (blank_q != '0) begin
      blank_q <= blank_q - CW'(1);
    end
  end

  // clear only honoured once both causes are gone
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            fault_q <= 1'b0;
    else if (set_fault)                     fault_q <= 1'b1;
    else if (clr_i && !itrip_i && !uv_i)    fault_q <= 1'b0;
  end

  assign hazard_o = set_fault || fault_q;
  assign fault_o  = fault_q;
endmodule

// File: rtl/gdrv_bridge_ctrl.sv
module gdrv_bridge_ctrl
  import gdrv_pkg::*;
#(
  parameter int unsigned N_PH      = 3,
  parameter int unsigned FILT_CYC  = 31,
  parameter int unsigned DEAD_CYC  = 70,
  parameter int unsigned BLANK_CYC = 40
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_PH-1:0] hin_ni,
  input  logic [N_PH-1:0] lin_ni,
  input  logic            itrip_i,
  input  logic            sd_i,
  input  logic            uv_vcc_i,
  input  logic [N_PH-1:0] uv_hs_i,
  input  logic            fclr_i,
  output logic [N_PH-1:0] ho_o,
  output logic [N_PH-1:0] lo_o,
  output logic            fault_n_o
);
  logic            hazard, fault_q, kill_all;
  logic [N_PH-1:0] en_hi, req_hi, req_lo, on_evt;
  gate_pair_t      gate [N_PH];

  assign kill_all = sd_i || hazard;

  gdrv_trip_guard #(.BLANK_CYC(BLANK_CYC)) u_guard (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .turn_on_i (|on_evt),
    .itrip_i   (itrip_i),
    .uv_i      (uv_vcc_i),
    .clr_i     (fclr_i),
    .hazard_o  (hazard),
    .fault_o   (fault_q)
  );

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    assign en_hi[p] = !kill_all && !uv_hs_i[p];

    gdrv_deglitch #(.FILT_CYC(FILT_CYC)) u_filt_hi (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (!en_hi[p]),
      .raw_i  (!hin_ni[p]),
      .q_o    (req_hi[p])
    );

    gdrv_deglitch #(.FILT_CYC(FILT_CYC)) u_filt_lo (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (kill_all),
      .raw_i  (!lin_ni[p]),
      .q_o    (req_lo[p])
    );

    gdrv_phase_dt #(.DEAD_CYC(DEAD_CYC)) u_dt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .req_hi_i  (req_hi[p]),
      .req_lo_i  (req_lo[p]),
      .en_hi_i   (en_hi[p]),
      .en_lo_i   (!kill_all),
      .gate_o    (gate[p]),
      .turn_on_o (on_evt[p])
    );

    assign ho_o[p] = gate[p].hi;
    assign lo_o[p] = gate[p].lo;
  end

  assign fault_n_o = !fault_q;
endmodule

// File: rtl/gdrv_bridge_chk.sv
module gdrv_bridge_chk #(
  parameter int unsigned N_PH     = 3,
  parameter int unsigned DEAD_CYC = 70
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            itrip_i,
  input logic            sd_i,
  input logic            uv_vcc_i,
  input logic [N_PH-1:0] uv_hs_i,
  input logic            fclr_i,
  input logic [N_PH-1:0] ho_o,
  input logic [N_PH-1:0] lo_o,
  input logic            fault_n_o
);
  localparam int unsigned CW = $clog2(DEAD_CYC + 1);

  for (genvar p = 0; p < N_PH; p++) begin : g_ph
    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         idle_cnt <= '0;
      else if (ho_o[p] || lo_o[p])         idle_cnt <= '0;
      else if (idle_cnt != CW'(DEAD_CYC))  idle_cnt <= idle_cnt + CW'(1);
    end

    assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ho_o[p] && lo_o[p]));

    assert_dead_hi_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(ho_o[p]) |-> idle_cnt == CW'(DEAD_CYC));

    assert_dead_lo_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lo_o[p]) |-> idle_cnt == CW'(DEAD_CYC));

    assert_hs_uv_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      uv_hs_i[p] |=> !ho_o[p]);
  end

  assert_fault_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fault_n_o) |-> $past(itrip_i || uv_vcc_i));

  assert_fault_kills_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_n_o |=> (ho_o == '0 && lo_o == '0));

  assert_clear_blocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fault_n_o && (itrip_i || uv_vcc_i)) |=> !fault_n_o);

  assert_clear_needed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_n_o) |-> $past(fclr_i));

  assert_sd_kills_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sd_i |=> (ho_o == '0 && lo_o == '0));
endmodule

bind gdrv_bridge_ctrl gdrv_bridge_chk #(.N_PH(N_PH), .DEAD_CYC(DEAD_CYC)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .itrip_i   (itrip_i),
  .sd_i      (sd_i),
  .uv_vcc_i  (uv_vcc_i),
  .uv_hs_i   (uv_hs_i),
  .fclr_i    (fclr_i),
  .ho_o      (ho_o),
  .lo_o      (lo_o),
  .fault_n_o (fault_n_o)
);

// File: tb/tb_gdrv_bridge_ctrl.sv
module tb_gdrv_bridge_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int FILT  = 4;
  localparam int DEAD  = 6;
  localparam int BLANK = 5;
  localparam int WD_CYC = 20000;
  localparam int NV = 8;

  // {hin_n[3], lin_n[3], sd, uv_hs[3], exp_ho[3], exp_lo[3]}
  localparam logic [15:0] VEC [NV] = '{
    {3'b111, 3'b111, 1'b0, 3'b000, 3'b000, 3'b000},
    {3'b110, 3'b111, 1'b0, 3'b000, 3'b001, 3'b000},
    {3'b110, 3'b101, 1'b0, 3'b000, 3'b001, 3'b010},
    {3'b111, 3'b100, 1'b0, 3'b000, 3'b000, 3'b011},
    {3'b010, 3'b011, 1'b0, 3'b000, 3'b001, 3'b000},
    {3'b000, 3'b111, 1'b0, 3'b001, 3'b110, 3'b000},
    {3'b000, 3'b111, 1'b1, 3'b000, 3'b000, 3'b000},
    {3'b000, 3'b111, 1'b0, 3'b000, 3'b111, 3'b000}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] hin_n = 3'b111, lin_n = 3'b111, uv_hs = 3'b000;
  logic       itrip = 1'b0, sd = 1'b0, uv_vcc = 1'b0, fclr = 1'b0;
  logic [2:0] ho, lo;
  logic       fault_n;

  int checks = 0, errors = 0, overlap_n = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gdrv_bridge_ctrl #(.N_PH(3), .FILT_CYC(FILT), .DEAD_CYC(DEAD), .BLANK_CYC(BLANK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .hin_ni(hin_n), .lin_ni(lin_n), .itrip_i(itrip),
    .sd_i(sd), .uv_vcc_i(uv_vcc), .uv_hs_i(uv_hs), .fclr_i(fclr),
    .ho_o(ho), .lo_o(lo), .fault_n_o(fault_n)
  );

  always @(negedge clk) if (rst_n && (ho & lo) != 3'b000) overlap_n++;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", WD_CYC, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, fall_t, rise_t, seen;
    settle(2);
    chk("R12 reset ho", int'(ho), 0);
    chk("R12 reset lo", int'(lo), 0);
    chk("R12 reset fault_n", int'(fault_n), 1);
    rst_n = 1'b1;
    settle(20);

    // R1 R3 R9 R10 vector table
    for (int i = 0; i < NV; i++) begin
      hin_n = VEC[i][15:13];
      lin_n = VEC[i][12:10];
      sd    = VEC[i][9];
      uv_hs = VEC[i][8:6];
      settle(24);
      chk($sformatf("R1 R3 R9 R10 vec %0d ho", i), int'(ho), int'(VEC[i][5:3]));
      chk($sformatf("R1 R3 R9 R10 vec %0d lo", i), int'(lo), int'(VEC[i][2:0]));
      chk($sformatf("R9 R10 vec %0d fault_n", i), int'(fault_n), 1);
    end

    // R2 latency from idle
    hin_n = 3'b111; lin_n = 3'b111;
    settle(30);
    hin_n = 3'b110;
    n = 0;
    while (!ho[0] && n < 60) begin tick(); n++; end
    chk("R2 filter latency", n, FILT + 1);

    // R4 swap gap
    settle(10);
    hin_n = 3'b111; lin_n = 3'b110;
    fall_t = -1; rise_t = -1;
    for (int i = 1; i < 60 && rise_t < 0; i++) begin
      tick();
      if (fall_t < 0 && !ho[0]) fall_t = i;
      if (lo[0]) rise_t = i;
    end
    chk("R4 dead gap", rise_t - fall_t, DEAD + 1);

    // R2 short pulse rejected
    lin_n = 3'b111;
    settle(30);
    lin_n = 3'b110;
    settle(FILT - 1);
    lin_n = 3'b111;
    seen = 0;
    for (int i = 0; i < 20; i++) begin tick(); if (lo != 3'b000) seen++; end
    chk("R2 short pulse lo", seen, 0);

    // R6 blanking, then R5 trip
    settle(20);
    hin_n = 3'b110; lin_n = 3'b101;
    n = 0;
    while (!ho[0] && n < 60) begin tick(); n++; end
    itrip = 1'b1;
    settle(4);
    itrip = 1'b0;
    chk("R6 blanked ho", int'(ho), 1);
    chk("R6 blanked lo", int'(lo), 2);
    chk("R6 blanked fault_n", int'(fault_n), 1);
    settle(3);
    itrip = 1'b1;
    tick();
    chk("R5 trip ho", int'(ho), 0);
    chk("R5 trip lo", int'(lo), 0);
    chk("R5 trip fault_n", int'(fault_n), 0);

    // R8 clear ignored while trip present
    fclr = 1'b1; tick(); fclr = 1'b0; tick();
    chk("R8 clear blocked fault_n", int'(fault_n), 0);
    itrip = 1'b0;
    settle(3);
    chk("R8 latched fault_n", int'(fault_n), 0);
    chk("R8 latched ho", int'(ho), 0);
    fclr = 1'b1; tick(); fclr = 1'b0;
    chk("R8 cleared fault_n", int'(fault_n), 1);

    // R11 resume after refilter
    settle(FILT);
    chk("R11 early ho", int'(ho), 0);
    tick();
    chk("R11 resume ho", int'(ho), 1);
    chk("R11 resume lo", int'(lo), 2);

    // R7 logic supply undervoltage
    settle(20);
    uv_vcc = 1'b1; tick();
    chk("R7 uv ho", int'(ho), 0);
    chk("R7 uv lo", int'(lo), 0);
    chk("R7 uv fault_n", int'(fault_n), 0);
    fclr = 1'b1; tick(); fclr = 1'b0; tick();
    chk("R7 clear blocked fault_n", int'(fault_n), 0);
    uv_vcc = 1'b0; tick();
    fclr = 1'b1; tick(); fclr = 1'b0;
    chk("R7 cleared fault_n", int'(fault_n), 1);
    settle(24);
    chk("R7 recovered ho", int'(ho), 1);

    // R9 shutdown at next edge, no fault
    sd = 1'b1; tick();
    chk("R9 sd ho", int'(ho), 0);
    chk("R9 sd lo", int'(lo), 0);
    chk("R9 sd fault_n", int'(fault_n), 1);
    sd = 1'b0;
    settle(24);
    chk("R9 sd release ho", int'(ho), 1);

    chk("R3 overlap monitor", overlap_n, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule